// File: doc/BRIEF.md
# Mask Test Flag Unit

This unit executes a packed mask-test operation. It takes two mask operands of up to 64 bits and the decoded fields of the instruction: an operand-size prefix bit, a width bit, the reserved register-specifier field and the mod field of the addressing byte. From the prefix and width bits it picks an effective test width of 8, 16, 32 or 64 bits. Only the low bits of each operand, up to that width, take part in the test.

On a legal strobe the unit sets the zero flag when the two operands have no common set bit. It sets the carry flag when every set bit of the second operand is also set in the first operand. It clears the sign, overflow, parity and auxiliary-carry flags. All other flag bits are copied from the flag input. The result is held in a flag register. If the encoding is illegal, the unit raises an invalid-opcode pulse and leaves the flag register unchanged. Neither operand is written back.

Top module: `mtest_unit`

## Requirements
- R1: On a legal strobe, flag bit 6 (zero) is 1 exactly when src1 AND src2, over the effective width, is all zeros.
- R2: On a legal strobe, flag bit 0 (carry) is 1 exactly when src2 AND NOT src1, over the effective width, is all zeros.
- R3: On a legal strobe, flag bits 2 (parity), 4 (aux carry), 7 (sign) and 11 (overflow) are written 0.
- R4: With the width bit 0, the effective width is 16 bits when the size prefix is 0 and 8 bits when it is 1.
- R5: With the width bit 1, the effective width is 64 bits when the size prefix is 0 and 32 bits when it is 1.
- R6: Operand bits at or above the effective width have no effect on either flag.
- R7: A strobe whose register-specifier field is not 4'b1111 is illegal: ud_o is 1 in the next cycle and flags_o keeps its value.
- R8: A strobe whose mod field is not 2'b11 is illegal: ud_o is 1 in the next cycle and flags_o keeps its value.
- R9: ud_o is a single-cycle pulse. It is 0 after a legal strobe and after a cycle with no strobe.
- R10: flags_o changes one clock edge after a legal strobe and holds its value in cycles with no strobe.
- R11: On a legal strobe, every flag bit other than 0, 2, 4, 6, 7 and 11 is copied from flags_i.
- R12: The asynchronous active-low reset clears flags_o and ud_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| opsz_pfx_i | input | 1 | Operand-size prefix present |
| wide_i | input | 1 | Width bit |
| vspec_i | input | 4 | Reserved register-specifier field |
| mod_i | input | 2 | Mod field of the addressing byte |
| src1_i | input | 64 | First mask operand |
| src2_i | input | 64 | Second mask operand |
| flags_i | input | 32 | Current status flags |
| flags_o | output | 32 | Registered status flags |
| ud_o | output | 1 | Invalid-opcode pulse |

## Verification
Both results, the flag word and the invalid-opcode pulse, are due on the first rising edge after the strobe. No other register sits in either path. The bench drives each operation on a falling edge and samples both outputs on the next falling edge. This places every check half a cycle after the edge that should have updated the outputs. Idle cycles are sampled in the same way, which confirms that the flags hold and the pulse has dropped one edge later.

// File: rtl/mtest_pkg.sv
package mtest_pkg;
  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } wid_e;

  // flag bit positions consumed by downstream logic
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 2;
  localparam int FLG_AF = 4;
  localparam int FLG_ZF = 6;
  localparam int FLG_SF = 7;
  localparam int FLG_OF = 11;

  localparam logic [3:0] VSPEC_OK = 4'b1111;
  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam int         MIN_BITS = 8;
endpackage

// File: rtl/mtest_decode.sv
module mtest_decode
  import mtest_pkg::*;
(
  input  logic       opsz_pfx_i,
  input  logic       wide_i,
  input  logic [3:0] vspec_i,
  input  logic [1:0] mod_i,
  output wid_e       wid_o,
  output logic       legal_o
);
  always_comb begin
    unique case ({wide_i, opsz_pfx_i})
      2'b00:   wid_o = WID_16;
      2'b01:   wid_o = WID_8;
      2'b10:   wid_o = WID_64;
      default: wid_o = WID_32;
    endcase
    legal_o = (vspec_i == VSPEC_OK) && (mod_i == MOD_REG);
  end
endmodule

// File: rtl/mtest_lanes.sv
module mtest_lanes
  import mtest_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [MASK_W-1:0] src1_i,
  input  logic [MASK_W-1:0] src2_i,
  input  wid_e              wid_i,
  output logic              any_and_o,
  output logic              any_andn_o
);
  localparam int NLANES = MASK_W / LANE_W;

  logic [NLANES-1:0] lane_and, lane_andn, lane_en;
  int unsigned       act_bits;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] a, b;
    assign a           = src1_i[g*LANE_W +: LANE_W];
    assign b           = src2_i[g*LANE_W +: LANE_W];
    assign lane_and[g]  = |(a & b);
    assign lane_andn[g] = |(b & ~a);
  end

  always_comb begin
    act_bits = MIN_BITS << wid_i;
    for (int i = 0; i < NLANES; i++)
      lane_en[i] = (i * LANE_W) < act_bits;
  end

  assign any_and_o  = |(lane_and & lane_en);
  assign any_andn_o = |(lane_andn & lane_en);
endmodule

// File: rtl/mtest_merge.sv
module mtest_merge
  import mtest_pkg::*;
#(
  parameter int FLAGS_W = 32
) (
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic               any_and_i,
  input  logic               any_andn_i,
  output logic [FLAGS_W-1:0] flags_o
);
  always_comb begin
    flags_o         = flags_i;
    flags_o[FLG_PF] = 1'b0;
    flags_o[FLG_AF] = 1'b0;
    flags_o[FLG_SF] = 1'b0;
    flags_o[FLG_OF] = 1'b0;
    flags_o[FLG_ZF] = ~any_and_i;
    flags_o[FLG_CF] = ~any_andn_i;
  end
endmodule

// File: rtl/mtest_unit.sv
module mtest_unit
  import mtest_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int LANE_W  = 8,
  parameter int FLAGS_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               opsz_pfx_i,
  input  logic               wide_i,
  input  logic [3:0]         vspec_i,
  input  logic [1:0]         mod_i,
  input  logic [MASK_W-1:0]  src1_i,
  input  logic [MASK_W-1:0]  src2_i,
  input  logic [FLAGS_W-1:0] flags_i,
  output logic [FLAGS_W-1:0] flags_o,
  output logic               ud_o
);
  wid_e               wid;
  logic               legal, any_and, any_andn;
  logic [FLAGS_W-1:0] flags_nx;

  mtest_decode u_dec (
    .opsz_pfx_i(opsz_pfx_i), .wide_i(wide_i), .vspec_i(vspec_i),
    .mod_i(mod_i), .wid_o(wid), .legal_o(legal)
  );

  mtest_lanes #(.MASK_W(MASK_W), .LANE_W(LANE_W)) u_lanes (
    .src1_i(src1_i), .src2_i(src2_i), .wid_i(wid),
    .any_and_o(any_and), .any_andn_o(any_andn)
  );

  mtest_merge #(.FLAGS_W(FLAGS_W)) u_merge (
    .flags_i(flags_i), .any_and_i(any_and), .any_andn_i(any_andn),
    .flags_o(flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      ud_o    <= 1'b0;
    end else begin
      ud_o <= valid_i && !legal;
      if (valid_i && legal) flags_o <= flags_nx;
    end
  end
endmodule

// File: rtl/mtest_chk.sv
module mtest_chk
  import mtest_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int FLAGS_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               opsz_pfx_i,
  input logic               wide_i,
  input logic [3:0]         vspec_i,
  input logic [1:0]         mod_i,
  input logic [MASK_W-1:0]  src1_i,
  input logic [MASK_W-1:0]  src2_i,
  input logic [FLAGS_W-1:0] flags_i,
  input logic [FLAGS_W-1:0] flags_o,
  input logic               ud_o
);
  logic ok_enc;
  assign ok_enc = (vspec_i == 4'b1111) && (mod_i == 2'b11);

  p_illegal_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ok_enc) |=> (ud_o && $stable(flags_o)));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!ud_o && $stable(flags_o)));

  p_legal_no_ud_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_enc) |=> !ud_o);

  p_cleared_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_enc) |=>
      !(flags_o[FLG_PF] || flags_o[FLG_AF] || flags_o[FLG_SF] || flags_o[FLG_OF]));

  p_zf_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_enc && opsz_pfx_i && !wide_i) |=>
      (flags_o[FLG_ZF] == $past((src1_i[7:0] & src2_i[7:0]) == 8'd0)));

  p_cf_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_enc && !opsz_pfx_i && wide_i) |=>
      (flags_o[FLG_CF] == $past((src2_i & ~src1_i) == '0)));

  p_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ok_enc) |=> (flags_o[FLAGS_W-1:12] == $past(flags_i[FLAGS_W-1:12])));
endmodule

bind mtest_unit mtest_chk #(.MASK_W(MASK_W), .FLAGS_W(FLAGS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opsz_pfx_i(opsz_pfx_i),
  .wide_i(wide_i), .vspec_i(vspec_i), .mod_i(mod_i), .src1_i(src1_i),
  .src2_i(src2_i), .flags_i(flags_i), .flags_o(flags_o), .ud_o(ud_o)
);

// File: tb/sim_mtest_unit.sv
module sim_mtest_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        opsz_pfx_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [3:0]  vspec_i = 4'hF;
  logic [1:0]  mod_i = 2'b11;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic [31:0] flags_i = '0;
  logic [31:0] flags_o;
  logic        ud_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic        done = 1'b0;
  logic [31:0] exp_flags = '0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk_i = ~clk_i;

  mtest_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opsz_pfx_i(opsz_pfx_i),
    .wide_i(wide_i), .vspec_i(vspec_i), .mod_i(mod_i), .src1_i(src1_i),
    .src2_i(src2_i), .flags_i(flags_i), .flags_o(flags_o), .ud_o(ud_o)
  );

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  function automatic int eff_bits(input logic w, input logic p);
    if (w) return p ? 32 : 64;
    return p ? 8 : 16;
  endfunction

  function automatic logic [31:0] model(input logic w, input logic p,
      input logic [63:0] a, input logic [63:0] b, input logic [31:0] f);
    int          n = eff_bits(w, p);
    logic [63:0] m = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    logic [31:0] r = f;
    r[2] = 0; r[4] = 0; r[7] = 0; r[11] = 0;
    r[6] = ((a & b & m) == '0);
    r[0] = ((b & ~a & m) == '0);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic p, input logic [3:0] vs,
      input logic [1:0] md, input logic [63:0] a, input logic [63:0] b,
      input logic [31:0] f);
    valid_i = 1'b1; wide_i = w; opsz_pfx_i = p; vspec_i = vs; mod_i = md;
    src1_i = a; src2_i = b; flags_i = f;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic legal_op(input string req, input logic w, input logic p,
      input logic [63:0] a, input logic [63:0] b);
    logic [31:0] f;
    rs = nxt(rs); f = rs[31:0];
    op(w, p, 4'hF, 2'b11, a, b, f);
    exp_flags = model(w, p, a, b, f);
    chk(req, flags_o, exp_flags);
    chk("R9", {31'd0, ud_o}, 32'd0);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R12", flags_o, 32'd0);
    chk("R12", {31'd0, ud_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // walking bits over every width
    for (int wc = 0; wc < 4; wc++) begin
      logic w = wc[1];
      logic p = !wc[0];
      int   n = eff_bits(w, p);
      for (int pos = 0; pos < 64; pos++) begin
        logic [63:0] bit1 = 64'd1 << pos;
        string rq = (pos >= n) ? "R6" : (w ? "R5 R1" : "R4 R1");
        legal_op(rq, w, p, bit1, bit1);
        legal_op((pos >= n) ? "R6" : (w ? "R5 R2" : "R4 R2"), w, p, '0, bit1);
        legal_op("R2 R6", w, p, ~bit1, ~bit1);
      end
    end

    // random operands, random flags
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      rs = nxt(rs); a = rs;
      rs = nxt(rs); b = (i % 3 == 0) ? (a & rs) : rs;
      legal_op("R1 R2 R3 R11", rs[40], rs[41], a, b);
    end

    // illegal specifier field
    for (int v = 0; v < 15; v++) begin
      rs = nxt(rs);
      op(1'b1, 1'b0, 4'(v), 2'b11, rs, ~rs, rs[31:0]);
      chk("R7", flags_o, exp_flags);
      chk("R7", {31'd0, ud_o}, 32'd1);
    end
    // illegal mod field
    for (int m = 0; m < 3; m++) begin
      rs = nxt(rs);
      op(1'b0, 1'b1, 4'hF, 2'(m), rs, rs, rs[63:32]);
      chk("R8", flags_o, exp_flags);
      chk("R8", {31'd0, ud_o}, 32'd1);
      @(negedge clk_i);
      chk("R9", {31'd0, ud_o}, 32'd0);
    end

    // idle cycles with moving inputs
    for (int i = 0; i < 8; i++) begin
      rs = nxt(rs);
      src1_i = rs; src2_i = ~rs; flags_i = rs[31:0]; vspec_i = 4'(i);
      @(negedge clk_i);
      chk("R10", flags_o, exp_flags);
      chk("R9", {31'd0, ud_o}, 32'd0);
    end

    // reset mid-run
    legal_op("R1", 1'b1, 1'b0, '0, 64'h5);
    rst_ni = 1'b0;
    #1;
    chk("R12", flags_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule